// File: doc/BRIEF.md
# Load/Store Address and Base-Update Unit

This unit sits between the integer register file and the data memory port of a core. It accepts one decoded integer load or store at a time, works out the effective address, issues a single memory request, and produces the new value of the base register. Two update modes are supported. In pre-update mode the offset is added before the access, and the sum is both the address and the new base. In post-update mode the memory is accessed at the unmodified base, and the base is then rewritten with base plus offset. The offset is a sign-extended 16-bit immediate or, in indexed form, the full value of a second register.

For loads the unit waits for the memory response, picks the addressed bytes out of the returned doubleword (little-endian lanes) and widens them to 64 bits, with zero or sign extension. For stores it places the low-order bytes of the source register into the addressed lanes and builds the byte-enable mask. An update-form load whose destination names the base register is flagged as invalid. It still accesses memory and writes the base, but it never writes the destination.

Top module: `lsu_addr_update`

## Requirements
- R1: With an immediate offset in pre-update mode, memAddr equals baseVal plus opImm sign-extended to 64 bits.
- R2: In post-update mode (opPost=1), memAddr equals baseVal unchanged, and baseWrVal equals baseVal plus the offset.
- R3: In pre-update mode (opPost=0), baseWrVal equals memAddr.
- R4: With opIndexed=1 the offset is the full 64-bit indexVal and opImm is ignored.
- R5: opSize encodes byte=0, halfword=1, word=2, doubleword=3. A load with opSigned=0 returns the 1<<opSize bytes that start at lane memAddr[2:0] of memRdata (lane k = bits 8k+7:8k), zero-extended to 64 bits.
- R6: A load with opSigned=1 copies the top bit of the loaded field into all higher bits of destVal.
- R7: For a store, memBe has ones exactly on lanes memAddr[2:0] through memAddr[2:0]+(1<<opSize)-1. memWdata holds the low 1<<opSize bytes of storeVal in those lanes and zeros in every other lane.
- R8: A load with opDest equal to opBase raises opInvalid together with memReqValid. It still raises baseWe, and destWe stays low for the whole operation.
- R9: memReqValid and baseWe pulse for one cycle in the cycle after opValid is accepted. opReady is low from then until the operation ends. For a load, destWe pulses in the cycle after memRspValid is sampled.
- R10: While in reset and directly after it, opReady is 1 and memReqValid, baseWe and destWe are 0.
- R11: memWrite is 1 for stores and 0 for loads. A store never raises destWe, and opReady returns high in the cycle after its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | A decoded operation is offered |
| opReady | output | 1 | Unit can accept an operation |
| opIsStore | input | 1 | 1 store, 0 load |
| opPost | input | 1 | 1 post-update, 0 pre-update |
| opIndexed | input | 1 | Offset from index register instead of immediate |
| opSize | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 doubleword |
| opSigned | input | 1 | Sign-extend loaded data |
| opImm | input | 16 | Signed immediate displacement |
| opDest | input | 5 | Destination register number (loads) |
| opBase | input | 5 | Base register number |
| baseVal | input | 64 | Base register value |
| indexVal | input | 64 | Index register value |
| storeVal | input | 64 | Store source register value |
| memReqValid | output | 1 | Memory request strobe |
| memAddr | output | 64 | Effective address |
| memSize | output | 2 | Access size of the request |
| memWrite | output | 1 | 1 write, 0 read |
| memWdata | output | 64 | Lane-aligned store data |
| memBe | output | 8 | Byte enables |
| memRspValid | input | 1 | Load data is valid |
| memRdata | input | 64 | Doubleword holding the loaded bytes |
| baseWe | output | 1 | Base register write strobe |
| baseWrIdx | output | 5 | Base register number to write |
| baseWrVal | output | 64 | New base value |
| destWe | output | 1 | Destination register write strobe |
| destIdx | output | 5 | Destination register number |
| destVal | output | 64 | Formatted load result |
| opInvalid | output | 1 | Destination equals base on a load |

## Verification
The assertions assume the access is naturally aligned, so that the lanes covered by memBe never wrap past the top of the doubleword. They also assume memRspValid comes only while a load is waiting for data, and that the operand inputs are stable in the cycle opValid is accepted. The directed stimulus keeps to these conditions. It uses addresses aligned to the access size, raises memRspValid once and only in the waiting cycle, and offers a new operation only when opReady is high.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } lsuState_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic captureOp;   // latch operands and computed address
    logic issueReq;    // memory request and base writeback cycle
    logic captureRsp;  // latch formatted load data
    logic fireDest;    // destination writeback cycle
  } lsuStrobe_t;

endpackage

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic       opIsStore,
  input  logic       memRspValid,
  output logic       opReady,
  output lsuStrobe_t strb
);

  lsuState_e stateQ, stateD;
  logic      storeQ;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (opValid) stateD = ST_REQ;
      ST_REQ:  stateD = storeQ ? ST_IDLE : ST_WAIT;
      ST_WAIT: if (memRspValid) stateD = ST_DONE;
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      storeQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (strb.captureOp) storeQ <= opIsStore;
    end
  end

  assign opReady         = (stateQ == ST_IDLE);
  assign strb.captureOp  = (stateQ == ST_IDLE) && opValid;
  assign strb.issueReq   = (stateQ == ST_REQ);
  assign strb.captureRsp = (stateQ == ST_WAIT) && memRspValid;
  assign strb.fireDest   = (stateQ == ST_DONE);

endmodule

// File: rtl/lsu_datapath.sv
module lsu_datapath
  import lsu_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 16,
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  lsuStrobe_t        strb,
  input  logic              opIsStore,
  input  logic              opPost,
  input  logic              opIndexed,
  input  logic [1:0]        opSize,
  input  logic              opSigned,
  input  logic [IMM_W-1:0]  opImm,
  input  logic [IDX_W-1:0]  opDest,
  input  logic [IDX_W-1:0]  opBase,
  input  logic [XLEN-1:0]   baseVal,
  input  logic [XLEN-1:0]   indexVal,
  input  logic [XLEN-1:0]   storeVal,
  input  logic [XLEN-1:0]   memRdata,
  output logic              memReqValid,
  output logic [XLEN-1:0]   memAddr,
  output logic [1:0]        memSize,
  output logic              memWrite,
  output logic [XLEN-1:0]   memWdata,
  output logic [XLEN/8-1:0] memBe,
  output logic              baseWe,
  output logic [IDX_W-1:0]  baseWrIdx,
  output logic [XLEN-1:0]   baseWrVal,
  output logic              destWe,
  output logic [IDX_W-1:0]  destIdx,
  output logic [XLEN-1:0]   destVal,
  output logic              opInvalid
);

  localparam int LANES  = XLEN / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int SH_W   = LANE_W + 3;

  function automatic logic [LANES-1:0] laneMask(input logic [1:0] sz);
    logic [LANES-1:0] m;
    m = '0;
    for (int i = 0; i < LANES; i++)
      if (i < (1 << sz)) m[i] = 1'b1;
    return m;
  endfunction

  // Operand side
  logic [XLEN-1:0]   offset, sum, effAddr, opBits, wrData;
  logic [LANE_W-1:0] lane;
  logic [LANES-1:0]  opLanes;

  assign offset  = opIndexed ? indexVal
                             : {{(XLEN-IMM_W){opImm[IMM_W-1]}}, opImm};
  assign sum     = baseVal + offset;
  assign effAddr = opPost ? baseVal : sum;
  assign lane    = effAddr[LANE_W-1:0];
  assign opLanes = laneMask(opSize);

  // Byte-lane expansion of masks, one slice per lane
  logic [XLEN-1:0] rdBits;
  logic [LANES-1:0] rdLanes;
  logic [1:0]       sizeQ;
  assign rdLanes = laneMask(sizeQ);

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign opBits[g*8 +: 8] = {8{opLanes[g]}};
    assign rdBits[g*8 +: 8] = {8{rdLanes[g]}};
  end

  assign wrData = (storeVal & opBits) << {lane, 3'b000};

  // Captured operation
  logic [XLEN-1:0]  addrQ, updQ, wdataQ, destValQ;
  logic [LANES-1:0] beQ;
  logic             signedQ, storeQ, invalidQ;
  logic [IDX_W-1:0] destIdxQ, baseIdxQ;

  // Load formatting
  logic [XLEN-1:0] shifted, loadFmt;
  logic [SH_W-1:0] signIdx;
  assign shifted = memRdata >> {addrQ[LANE_W-1:0], 3'b000};
  assign signIdx = SH_W'((8 << sizeQ) - 1);
  assign loadFmt = (shifted & rdBits)
                 | ((signedQ && shifted[signIdx]) ? ~rdBits : '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      updQ     <= '0;
      wdataQ   <= '0;
      beQ      <= '0;
      sizeQ    <= '0;
      signedQ  <= 1'b0;
      storeQ   <= 1'b0;
      invalidQ <= 1'b0;
      destIdxQ <= '0;
      baseIdxQ <= '0;
      destValQ <= '0;
    end else begin
      if (strb.captureOp) begin
        addrQ    <= effAddr;
        updQ     <= sum;
        wdataQ   <= wrData;
        beQ      <= opLanes << lane;
        sizeQ    <= opSize;
        signedQ  <= opSigned;
        storeQ   <= opIsStore;
        invalidQ <= !opIsStore && (opDest == opBase);
        destIdxQ <= opDest;
        baseIdxQ <= opBase;
      end
      if (strb.captureRsp) destValQ <= loadFmt;
    end
  end

  assign memReqValid = strb.issueReq;
  assign memAddr     = addrQ;
  assign memSize     = sizeQ;
  assign memWrite    = storeQ;
  assign memWdata    = wdataQ;
  assign memBe       = beQ;
  assign baseWe      = strb.issueReq;
  assign baseWrIdx   = baseIdxQ;
  assign baseWrVal   = updQ;
  assign destWe      = strb.fireDest && !invalidQ;
  assign destIdx     = destIdxQ;
  assign destVal     = destValQ;
  assign opInvalid   = strb.issueReq && invalidQ;

endmodule

// File: rtl/lsu_addr_update.sv
module lsu_addr_update
  import lsu_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 16,
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  output logic              opReady,
  input  logic              opIsStore,
  input  logic              opPost,
  input  logic              opIndexed,
  input  logic [1:0]        opSize,
  input  logic              opSigned,
  input  logic [IMM_W-1:0]  opImm,
  input  logic [IDX_W-1:0]  opDest,
  input  logic [IDX_W-1:0]  opBase,
  input  logic [XLEN-1:0]   baseVal,
  input  logic [XLEN-1:0]   indexVal,
  input  logic [XLEN-1:0]   storeVal,
  output logic              memReqValid,
  output logic [XLEN-1:0]   memAddr,
  output logic [1:0]        memSize,
  output logic              memWrite,
  output logic [XLEN-1:0]   memWdata,
  output logic [XLEN/8-1:0] memBe,
  input  logic              memRspValid,
  input  logic [XLEN-1:0]   memRdata,
  output logic              baseWe,
  output logic [IDX_W-1:0]  baseWrIdx,
  output logic [XLEN-1:0]   baseWrVal,
  output logic              destWe,
  output logic [IDX_W-1:0]  destIdx,
  output logic [XLEN-1:0]   destVal,
  output logic              opInvalid
);

  lsuStrobe_t strb;

  lsu_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .opValid     (opValid),
    .opIsStore   (opIsStore),
    .memRspValid (memRspValid),
    .opReady     (opReady),
    .strb        (strb)
  );

  lsu_datapath #(.XLEN(XLEN), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .opIsStore   (opIsStore),
    .opPost      (opPost),
    .opIndexed   (opIndexed),
    .opSize      (opSize),
    .opSigned    (opSigned),
    .opImm       (opImm),
    .opDest      (opDest),
    .opBase      (opBase),
    .baseVal     (baseVal),
    .indexVal    (indexVal),
    .storeVal    (storeVal),
    .memRdata    (memRdata),
    .memReqValid (memReqValid),
    .memAddr     (memAddr),
    .memSize     (memSize),
    .memWrite    (memWrite),
    .memWdata    (memWdata),
    .memBe       (memBe),
    .baseWe      (baseWe),
    .baseWrIdx   (baseWrIdx),
    .baseWrVal   (baseWrVal),
    .destWe      (destWe),
    .destIdx     (destIdx),
    .destVal     (destVal),
    .opInvalid   (opInvalid)
  );

endmodule

// File: rtl/lsu_addr_update_chk.sv
module lsu_addr_update_chk #(
  parameter int XLEN  = 64,
  parameter int IMM_W = 16,
  parameter int IDX_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic              opReady,
  input logic              opPost,
  input logic [XLEN-1:0]   baseVal,
  input logic              memReqValid,
  input logic [XLEN-1:0]   memAddr,
  input logic [1:0]        memSize,
  input logic              memWrite,
  input logic [XLEN/8-1:0] memBe,
  input logic              memRspValid,
  input logic              baseWe,
  input logic [IDX_W-1:0]  baseWrIdx,
  input logic [XLEN-1:0]   baseWrVal,
  input logic              destWe,
  input logic [IDX_W-1:0]  destIdx,
  input logic              opInvalid
);

  localparam int IMM_BITS = IMM_W;

  assert_req_after_accept_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> $past(opValid && opReady));

  assert_busy_in_req_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (!opReady && baseWe));

  assert_dest_after_rsp_R9: assert property (@(posedge clk) disable iff (!rstN)
    destWe |-> $past(memRspValid));

  assert_post_base_addr_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && $past(opPost)) |-> (memAddr == $past(baseVal)));

  assert_pre_same_value_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !$past(opPost)) |-> (memAddr == baseWrVal));

  assert_lane_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> ($countones(memBe) == (1 << memSize)));

  assert_invalid_is_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    opInvalid |-> (memReqValid && !memWrite && baseWe));

  assert_no_dest_on_base_R8: assert property (@(posedge clk) disable iff (!rstN)
    destWe |-> (destIdx != baseWrIdx));

  assert_store_quick_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memWrite) |=> (opReady && !destWe));

  initial assert (IMM_BITS > 0 && IMM_BITS <= XLEN);

endmodule

bind lsu_addr_update lsu_addr_update_chk #(.XLEN(XLEN), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/lsu_addr_update_tb.sv
`timescale 1ns/1ps
module lsu_addr_update_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0, opIsStore = 1'b0, opPost = 1'b0, opIndexed = 1'b0, opSigned = 1'b0;
  logic [1:0]  opSize = '0;
  logic [15:0] opImm = '0;
  logic [4:0]  opDest = '0, opBase = '0;
  logic [63:0] baseVal = '0, indexVal = '0, storeVal = '0, memRdata = '0;
  logic        memRspValid = 1'b0;
  logic        opReady, memReqValid, memWrite, baseWe, destWe, opInvalid;
  logic [63:0] memAddr, memWdata, baseWrVal, destVal;
  logic [1:0]  memSize;
  logic [7:0]  memBe;
  logic [4:0]  baseWrIdx, destIdx;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  lsu_addr_update u_dut (.*);

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] sext16(input logic [15:0] v);
    return {{48{v[15]}}, v};
  endfunction

  // Offer one operation; returns at the negedge of the request cycle
  task automatic issue(input logic st, input logic post, input logic idx, input logic [1:0] sz,
                       input logic sgn, input logic [4:0] dst, input logic [4:0] bas,
                       input logic [15:0] imm, input logic [63:0] bv, input logic [63:0] iv,
                       input logic [63:0] sv);
    @(negedge clk);
    opIsStore = st; opPost = post; opIndexed = idx; opSize = sz; opSigned = sgn;
    opDest = dst; opBase = bas; opImm = imm; baseVal = bv; indexVal = iv; storeVal = sv;
    opValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    opValid = 1'b0;
  endtask

  // Supply load data in the waiting cycle; returns at the negedge of the writeback cycle
  task automatic respond(input logic [63:0] data);
    @(posedge clk);
    @(negedge clk);
    memRspValid = 1'b1;
    memRdata = data;
    @(posedge clk);
    @(negedge clk);
    memRspValid = 1'b0;
  endtask

  task automatic finishLoad(input string req);
    @(posedge clk);
    @(negedge clk);
    chk(req, "opReady after load", {63'd0, opReady}, 64'd1);
  endtask

  task automatic testReset();
    chk("R10", "opReady", {63'd0, opReady}, 64'd1);
    chk("R10", "memReqValid", {63'd0, memReqValid}, 64'd0);
    chk("R10", "baseWe", {63'd0, baseWe}, 64'd0);
    chk("R10", "destWe", {63'd0, destWe}, 64'd0);
  endtask

  task automatic testPreImmWord();
    issue(0, 0, 0, 2'd2, 0, 5'd3, 5'd4, 16'hFFF8, 64'h1000, 64'h0, 64'h0);
    chk("R9", "memReqValid", {63'd0, memReqValid}, 64'd1);
    chk("R9", "opReady low", {63'd0, opReady}, 64'd0);
    chk("R1", "addr", memAddr, 64'h1000 + sext16(16'hFFF8));
    chk("R3", "base wb", baseWrVal, 64'h0FF8);
    chk("R9", "baseWe", {63'd0, baseWe}, 64'd1);
    chk("R11", "memWrite load", {63'd0, memWrite}, 64'd0);
    respond(64'h8765_4321_CAFE_F00D);
    chk("R9", "destWe", {63'd0, destWe}, 64'd1);
    chk("R5", "word zext", destVal, 64'h0000_0000_CAFE_F00D);
    chk("R9", "destIdx", {59'd0, destIdx}, 64'd3);
    finishLoad("R9");
  endtask

  task automatic testPostImmByte();
    issue(0, 1, 0, 2'd0, 0, 5'd1, 5'd2, 16'h0010, 64'h2005, 64'h0, 64'h0);
    chk("R2", "addr", memAddr, 64'h2005);
    chk("R2", "base wb", baseWrVal, 64'h2015);
    chk("R2", "baseWrIdx", {59'd0, baseWrIdx}, 64'd2);
    respond(64'h0011_AA22_3344_5566);
    chk("R5", "byte lane5 zext", destVal, 64'h0000_0000_0000_00AA);
    finishLoad("R5");
  endtask

  task automatic testPostIdxHalfSigned();
    issue(0, 1, 1, 2'd1, 1, 5'd5, 5'd6, 16'h7777, 64'h3002, 64'h100, 64'h0);
    chk("R4", "addr", memAddr, 64'h3002);
    chk("R4", "base wb index", baseWrVal, 64'h3102);
    chk("R7", "read be", {56'd0, memBe}, 64'h0C);
    respond(64'h0000_0000_8001_0000);
    chk("R6", "half sext", destVal, 64'hFFFF_FFFF_FFFF_8001);
    finishLoad("R6");
  endtask

  task automatic testPreIdxWordSigned();
    issue(0, 0, 1, 2'd2, 1, 5'd8, 5'd9, 16'h8000, 64'h4000, 64'hFFFF_FFFF_FFFF_FFFC, 64'h0);
    chk("R4", "addr neg index", memAddr, 64'h3FFC);
    chk("R3", "base wb", baseWrVal, 64'h3FFC);
    respond(64'h7ABC_DEF0_1111_2222);
    chk("R6", "word positive sext", destVal, 64'h0000_0000_7ABC_DEF0);
    finishLoad("R6");
  endtask

  task automatic testPostImmDword();
    issue(0, 1, 0, 2'd3, 0, 5'd10, 5'd11, 16'h0008, 64'h5000, 64'h0, 64'h0);
    chk("R2", "addr", memAddr, 64'h5000);
    chk("R2", "base wb", baseWrVal, 64'h5008);
    chk("R7", "dword be", {56'd0, memBe}, 64'hFF);
    respond(64'hF0E1_D2C3_B4A5_9687);
    chk("R5", "dword", destVal, 64'hF0E1_D2C3_B4A5_9687);
    finishLoad("R5");
  endtask

  task automatic testStoreBytePost();
    issue(1, 1, 0, 2'd0, 0, 5'd12, 5'd13, 16'h0001, 64'h6003, 64'h0, 64'h1122_3344_5566_7788);
    chk("R11", "memWrite", {63'd0, memWrite}, 64'd1);
    chk("R2", "addr", memAddr, 64'h6003);
    chk("R2", "base wb", baseWrVal, 64'h6004);
    chk("R7", "be", {56'd0, memBe}, 64'h08);
    chk("R7", "wdata", memWdata, 64'h0000_0000_8800_0000);
    @(posedge clk);
    @(negedge clk);
    chk("R11", "ready after store", {63'd0, opReady}, 64'd1);
    chk("R11", "no destWe", {63'd0, destWe}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R11", "no destWe later", {63'd0, destWe}, 64'd0);
  endtask

  task automatic testStoreHalfPre();
    issue(1, 0, 0, 2'd1, 0, 5'd0, 5'd14, 16'h0006, 64'h7000, 64'h0, 64'h1122_3344_5566_7788);
    chk("R1", "addr", memAddr, 64'h7006);
    chk("R3", "base wb", baseWrVal, 64'h7006);
    chk("R7", "be", {56'd0, memBe}, 64'hC0);
    chk("R7", "wdata", memWdata, 64'h7788_0000_0000_0000);
  endtask

  task automatic testStoreDwordIdx();
    issue(1, 0, 1, 2'd3, 0, 5'd0, 5'd15, 16'hFFFF, 64'h8000, 64'h10, 64'hDEAD_BEEF_0123_4567);
    chk("R4", "addr ignores imm", memAddr, 64'h8010);
    chk("R7", "be", {56'd0, memBe}, 64'hFF);
    chk("R7", "wdata", memWdata, 64'hDEAD_BEEF_0123_4567);
  endtask

  task automatic testInvalid();
    issue(0, 1, 0, 2'd0, 0, 5'd7, 5'd7, 16'h0004, 64'h9000, 64'h0, 64'h0);
    chk("R8", "opInvalid", {63'd0, opInvalid}, 64'd1);
    chk("R8", "baseWe", {63'd0, baseWe}, 64'd1);
    chk("R8", "base wb", baseWrVal, 64'h9004);
    respond(64'h0000_0000_0000_0055);
    chk("R8", "destWe suppressed", {63'd0, destWe}, 64'd0);
    finishLoad("R8");
    chk("R8", "destWe still low", {63'd0, destWe}, 64'd0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    testReset();
    testPreImmWord();
    testPostImmByte();
    testPostIdxHalfSigned();
    testPreIdxWordSigned();
    testPostImmDword();
    testStoreBytePost();
    testStoreHalfPre();
    testStoreDwordIdx();
    testInvalid();
    repeat (2) @(negedge clk);
    summary();
  end

endmodule